// File: doc/BRIEF.md
# Parallel flash programming controller

This block is the device-side logic for byte-wide programming of an on-chip code memory of 2^AW bytes (4096 by default). A programmer drives a high-voltage enable, four mode-select pins, an active-low program strobe and an 8-bit data bus. The block decodes these into one of six operations: write a code byte, read a code byte, program either of two lock bits, erase the whole chip, or read the identification bytes.

The block does not accept an address. An internal counter is cleared by a rising edge on a sequence-reset pin and advanced by a rising edge on a step pin. Programming is self-timed. The ready output drops while an operation runs. During a code write, a read of the byte being written returns its top bit inverted, so the programmer can also detect completion by polling the data bus.

The storage is a behavioural register array. All timings are counted in clock cycles and set by parameters.

Top module: `bytewide_prog_ctl`

## Requirements
- R1: A rising edge on `seq_rst` clears the address counter to zero at the next clock edge. This takes priority over a `step` edge in the same cycle. The synchronous `rst` also clears the counter.
- R2: A rising edge on `step` increments the address counter. After address 2^AW-1 the counter wraps to 0.
- R3: The mode codes on `mode_sel` are: 0x5 write code, 0x6 read code, 0xA program lock bit 1, 0x9 program lock bit 2, 0xC chip erase, 0x3 read signature. Write, lock and erase codes act only while `hv_en`=1. Read codes act only while `hv_en`=0. In any other combination `rdata` is 0xFF and the strobe has no effect.
- R4: In write-code mode, the low-to-high return of `prog_n` starts a write. `rdy` is 1 after reset. It is 0 from the clock edge that detects the return, for exactly WR_CYCLES cycles. Lock-bit programming uses the same timing.
- R5: A code write changes the array only if the addressed byte reads 0xFF when the write starts. A write to any other byte leaves that byte unchanged.
- R6: While a code write runs, reading its address returns the written byte with bit 7 inverted. After `rdy` returns to 1, the same read returns the true byte.
- R7: A write, lock or erase command given while `rdy`=0 is ignored and does not lengthen the busy period.
- R8: In erase mode, holding `prog_n` low for ERASE_HOLD consecutive clock edges starts an erase. The erase sets every byte to 0xFF, clears both lock bits, and holds `rdy` at 0 for 2^AW cycles. A shorter hold has no effect.
- R9: Once lock bit 1 is programmed, code writes are ignored: `rdy` stays 1 and the byte is unchanged.
- R10: With both lock bits programmed, code reads return 0xFF. Signature reads still work.
- R11: A signature read returns 0x1E at address 0, 0x41 at address 1 and 0xFF at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_en | input | 1 | High-voltage enable; 1 selects write-class operations |
| mode_sel | input | 4 | Operation select code |
| prog_n | input | 1 | Active-low program strobe |
| seq_rst | input | 1 | Rising edge clears the address counter |
| step | input | 1 | Rising edge advances the address counter |
| wdata | input | 8 | Byte to program |
| rdata | output | 8 | Read data, polling view or 0xFF |
| rdy | output | 1 | 1 = idle, 0 = operation in progress |

## Verification
The two address-counter events can fall in the same clock cycle. The bench walks the counter to a known non-zero address, then raises `seq_rst` and `step` in the same cycle. It then reads back the code byte and expects the address-0 content. One further step must give the address-1 content, which proves that the clear took priority and that the advance was dropped. A second overlap is a new write strobe that arrives inside a running write. The bench measures the remaining busy time to confirm that the timer was not restarted. It then reads the second target address to confirm that the data was discarded.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam logic [3:0] MS_WRITE = 4'h5;
    localparam logic [3:0] MS_READ  = 4'h6;
    localparam logic [3:0] MS_LOCK1 = 4'hA;
    localparam logic [3:0] MS_LOCK2 = 4'h9;
    localparam logic [3:0] MS_ERASE = 4'hC;
    localparam logic [3:0] MS_SIG   = 4'h3;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;
    localparam logic [7:0] SIG_ID0    = 8'h1E;
    localparam logic [7:0] SIG_ID1    = 8'h41;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_WRITE,
        CMD_LOCK1,
        CMD_LOCK2,
        CMD_ERASE,
        CMD_READ,
        CMD_SIG
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_LOCK,
        ST_ERASE
    } seq_st_e;

    typedef struct packed {
        logic lb2;
        logic lb1;
    } lock_t;

    function automatic cmd_e decode_cmd(input logic hv, input logic [3:0] ms);
        cmd_e c;
        c = CMD_IDLE;
        case (ms)
            MS_WRITE: c = hv ? CMD_WRITE : CMD_IDLE;
            MS_LOCK1: c = hv ? CMD_LOCK1 : CMD_IDLE;
            MS_LOCK2: c = hv ? CMD_LOCK2 : CMD_IDLE;
            MS_ERASE: c = hv ? CMD_ERASE : CMD_IDLE;
            MS_READ:  c = hv ? CMD_IDLE  : CMD_READ;
            MS_SIG:   c = hv ? CMD_IDLE  : CMD_SIG;
            default:  c = CMD_IDLE;
        endcase
        return c;
    endfunction

    function automatic logic [7:0] poll_view(input logic [7:0] b);
        return {~b[7], b[6:0]};
    endfunction

    function automatic logic [7:0] sig_lookup(input logic at0, input logic at1);
        if (at0)      return SIG_ID0;
        else if (at1) return SIG_ID1;
        else          return BLANK_BYTE;
    endfunction

endpackage

// File: rtl/pc_addr_seq.sv
module pc_addr_seq #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seq_rst,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic sr_q;
    logic st_q;
    logic clr_edge;
    logic adv_edge;

    // edge history tracks the pins unconditionally
    always_ff @(posedge clk) begin
        sr_q <= seq_rst;
        st_q <= step;
    end

    assign clr_edge = seq_rst & ~sr_q;
    assign adv_edge = step & ~st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (clr_edge) begin
            addr <= '0;
        end else if (adv_edge) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/pc_op_seq.sv
module pc_op_seq
    import pc_pkg::*;
#(
    parameter int AW         = 12,
    parameter int WR_CYCLES  = 2400,
    parameter int ERASE_HOLD = 20000
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd,
    input  logic          prog_n,
    input  logic          prog_locked,
    output logic          busy,
    output logic          wr_go,
    output logic          lk1_go,
    output logic          lk2_go,
    output logic          era_go,
    output logic          era_we,
    output logic [AW-1:0] era_addr,
    output logic          poll_on
);
    localparam int DEPTH = 1 << AW;
    localparam int CMAX  = (WR_CYCLES > DEPTH) ? WR_CYCLES : DEPTH;
    localparam int CW    = $clog2(CMAX + 1);
    localparam int HW    = $clog2(ERASE_HOLD + 1);

    seq_st_e       st;
    logic [CW-1:0] cnt;
    logic [HW-1:0] hold;
    logic          pn_q;
    logic          str_rise;
    logic          idle;

    always_ff @(posedge clk) begin
        pn_q <= prog_n;
    end

    assign str_rise = prog_n & ~pn_q;
    assign idle     = (st == ST_IDLE);

    assign wr_go  = idle & str_rise & (cmd == CMD_WRITE) & ~prog_locked;
    assign lk1_go = idle & str_rise & (cmd == CMD_LOCK1);
    assign lk2_go = idle & str_rise & (cmd == CMD_LOCK2);
    assign era_go = idle & ~prog_n & (cmd == CMD_ERASE) & (hold == HW'(ERASE_HOLD - 1));

    // low-time counter for the erase strobe, saturating so one hold fires once
    always_ff @(posedge clk) begin
        if (rst || prog_n || (cmd != CMD_ERASE)) begin
            hold <= '0;
        end else if (hold != HW'(ERASE_HOLD)) begin
            hold <= hold + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (wr_go) begin
                        st  <= ST_WRITE;
                        cnt <= CW'(WR_CYCLES - 1);
                    end else if (lk1_go || lk2_go) begin
                        st  <= ST_LOCK;
                        cnt <= CW'(WR_CYCLES - 1);
                    end else if (era_go) begin
                        st  <= ST_ERASE;
                        cnt <= CW'(DEPTH - 1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy     = ~idle;
    assign poll_on  = (st == ST_WRITE);
    assign era_we   = (st == ST_ERASE);
    assign era_addr = cnt[AW-1:0];
endmodule

// File: rtl/pc_code_array.sv
module pc_code_array #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdat,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdat
);
    localparam int DEPTH = 1 << AW;

    // contents are non-volatile: no reset
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdat;
        end
    end

    assign rdat = mem[raddr];
endmodule

// File: rtl/bytewide_prog_ctl.sv
module bytewide_prog_ctl
    import pc_pkg::*;
#(
    parameter int AW         = 12,
    parameter int WR_CYCLES  = 2400,
    parameter int ERASE_HOLD = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hv_en,
    input  logic [3:0] mode_sel,
    input  logic       prog_n,
    input  logic       seq_rst,
    input  logic       step,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rdy
);
    cmd_e          cmd;
    logic [AW-1:0] addr_q;
    lock_t         lock_q;
    logic [AW-1:0] wr_addr_q;
    logic [7:0]    wr_byte_q;
    logic [7:0]    mem_rd;
    logic          busy;
    logic          wr_go;
    logic          lk1_go;
    logic          lk2_go;
    logic          era_go;
    logic          era_we;
    logic [AW-1:0] era_addr;
    logic          poll_on;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [7:0]    arr_wdat;

    assign cmd = decode_cmd(hv_en, mode_sel);

    pc_addr_seq #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .seq_rst (seq_rst),
        .step    (step),
        .addr    (addr_q)
    );

    pc_op_seq #(
        .AW         (AW),
        .WR_CYCLES  (WR_CYCLES),
        .ERASE_HOLD (ERASE_HOLD)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .prog_n      (prog_n),
        .prog_locked (lock_q.lb1),
        .busy        (busy),
        .wr_go       (wr_go),
        .lk1_go      (lk1_go),
        .lk2_go      (lk2_go),
        .era_go      (era_go),
        .era_we      (era_we),
        .era_addr    (era_addr),
        .poll_on     (poll_on)
    );

    pc_code_array #(.AW(AW), .DW(8)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdat  (arr_wdat),
        .raddr (addr_q),
        .rdat  (mem_rd)
    );

    // array write port: erase walker or a blank-byte program
    always_comb begin
        if (era_we) begin
            arr_we    = 1'b1;
            arr_waddr = era_addr;
            arr_wdat  = BLANK_BYTE;
        end else begin
            arr_we    = wr_go && (mem_rd == BLANK_BYTE);
            arr_waddr = addr_q;
            arr_wdat  = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else if (era_go) begin
            lock_q <= '0;
        end else begin
            if (lk1_go) lock_q.lb1 <= 1'b1;
            if (lk2_go) lock_q.lb2 <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr_q <= '0;
            wr_byte_q <= '0;
        end else if (wr_go) begin
            wr_addr_q <= addr_q;
            wr_byte_q <= wdata;
        end
    end

    always_comb begin
        rdata = BLANK_BYTE;
        case (cmd)
            CMD_READ: begin
                if (!(lock_q.lb1 && lock_q.lb2)) begin
                    if (poll_on && (addr_q == wr_addr_q)) rdata = poll_view(wr_byte_q);
                    else                                  rdata = mem_rd;
                end
            end
            CMD_SIG: rdata = sig_lookup(addr_q == AW'(0), addr_q == AW'(1));
            default: rdata = BLANK_BYTE;
        endcase
    end

    assign rdy = ~busy;
endmodule

// File: rtl/pc_chk.sv
module pc_chk
    import pc_pkg::*;
#(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          hv_en,
    input logic [3:0]    mode_sel,
    input logic          prog_n,
    input logic          seq_rst,
    input logic          step,
    input logic [7:0]    rdata,
    input logic          rdy,
    input logic [AW-1:0] addr,
    input logic          lb1,
    input logic          lb2,
    input logic [AW-1:0] wr_addr,
    input logic          era_go
);
    AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_rst) |=> (addr == '0)); // R1

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$rose(seq_rst) && $rose(step) && (addr == '1)) |=> (addr == '0)); // R2

    AST_RDY_DROP: assert property (@(posedge clk) disable iff (rst)
        (hv_en && (mode_sel == MS_WRITE) && $rose(prog_n) && rdy && !lb1) |=> !rdy); // R4

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!rdy && hv_en && (mode_sel == MS_WRITE) && $rose(prog_n)) |=> $stable(wr_addr)); // R7

    AST_ERASE_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        era_go |=> (!lb1 && !lb2)); // R8

    AST_LOCKED_READ: assert property (@(posedge clk) disable iff (rst)
        (!hv_en && (mode_sel == MS_READ) && lb1 && lb2) |-> (rdata == BLANK_BYTE)); // R10

    AST_SIG_ID: assert property (@(posedge clk) disable iff (rst)
        (!hv_en && (mode_sel == MS_SIG) && (addr == '0)) |-> (rdata == SIG_ID0)); // R11
endmodule

bind bytewide_prog_ctl pc_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hv_en    (hv_en),
    .mode_sel (mode_sel),
    .prog_n   (prog_n),
    .seq_rst  (seq_rst),
    .step     (step),
    .rdata    (rdata),
    .rdy      (rdy),
    .addr     (addr_q),
    .lb1      (lock_q.lb1),
    .lb2      (lock_q.lb2),
    .wr_addr  (wr_addr_q),
    .era_go   (era_go)
);

// File: tb/tb_bytewide_prog_ctl.sv
module tb_bytewide_prog_ctl;
    import pc_pkg::*;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int WR    = 12;
    localparam int EH    = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic       hv_en;
    logic [3:0] mode_sel;
    logic       prog_n;
    logic       seq_rst;
    logic       step;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       rdy;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    bytewide_prog_ctl #(.AW(AW), .WR_CYCLES(WR), .ERASE_HOLD(EH)) dut (
        .clk(clk), .rst(rst), .hv_en(hv_en), .mode_sel(mode_sel), .prog_n(prog_n),
        .seq_rst(seq_rst), .step(step), .wdata(wdata), .rdata(rdata), .rdy(rdy)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chki(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart_addr();
        seq_rst = 1'b1; tick();
        seq_rst = 1'b0; tick();
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) begin
            step = 1'b1; tick();
            step = 1'b0; tick();
        end
    endtask

    task automatic strobe(input logic [3:0] ms, input logic [7:0] d);
        hv_en = 1'b1; mode_sel = ms; wdata = d;
        prog_n = 1'b0; tick();
        prog_n = 1'b1; tick();
    endtask

    task automatic rd(input logic [3:0] ms, output logic [7:0] v);
        hv_en = 1'b0; mode_sel = ms;
        #1 v = rdata;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!rdy && n < 100000) begin
            n++;
            tick();
        end
    endtask

    task automatic erase_hold(input int edges, output int n);
        hv_en = 1'b1; mode_sel = MS_ERASE;
        prog_n = 1'b0;
        repeat (edges) tick();
        prog_n = 1'b1;
        busy_len(n);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) % 256);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        rst = 1'b1; hv_en = 1'b0; mode_sel = MS_SIG; prog_n = 1'b1;
        seq_rst = 1'b0; step = 1'b0; wdata = 8'h00;
        repeat (3) tick();
        rst = 1'b0; tick();

        // reset state
        chki("R4 rdy after reset", int'(rdy), 1);
        rd(MS_SIG, v); chk8("R1/R11 address zero after reset", v, SIG_ID0);

        // full erase
        erase_hold(EH, n); chki("R8 erase busy length", n, DEPTH);
        restart_addr();
        for (int a = 0; a < DEPTH; a++) begin
            rd(MS_READ, v); chk8($sformatf("R8 blank at %0d", a), v, 8'hFF);
            advance(1);
        end

        // program every byte, checking busy time and polling view
        restart_addr();
        for (int a = 0; a < DEPTH; a++) begin
            strobe(MS_WRITE, pat(a));
            rd(MS_READ, v); chk8($sformatf("R6 poll at %0d", a), v, {~pat(a)[7], pat(a)[6:0]});
            busy_len(n); chki("R4 write busy length", n, WR);
            rd(MS_READ, v); chk8($sformatf("R6 true data at %0d", a), v, pat(a));
            advance(1);
        end

        // non-blank byte keeps its value
        restart_addr(); advance(5);
        strobe(MS_WRITE, 8'h00); busy_len(n);
        rd(MS_READ, v); chk8("R5 non-blank unchanged", v, pat(5));

        // second erase, then a write strobe during a running write
        erase_hold(EH, n); chki("R8 second erase length", n, DEPTH);
        restart_addr(); advance(2);
        strobe(MS_WRITE, 8'h5A);
        advance(1);
        strobe(MS_WRITE, 8'h33);
        busy_len(n); chki("R7 busy not extended", n, WR - 4);
        rd(MS_READ, v); chk8("R7 ignored byte stays blank", v, 8'hFF);
        restart_addr(); advance(2);
        rd(MS_READ, v); chk8("R7 first write kept", v, 8'h5A);

        // lock bit 1 blocks programming
        strobe(MS_LOCK1, 8'h00); busy_len(n); chki("R4 lock program length", n, WR);
        advance(2);
        strobe(MS_WRITE, 8'h11);
        chki("R9 locked write leaves rdy high", int'(rdy), 1);
        rd(MS_READ, v); chk8("R9 locked write no change", v, 8'hFF);
        restart_addr(); advance(2);
        rd(MS_READ, v); chk8("R10 lock1 alone still readable", v, 8'h5A);

        // both locks: reads blanked, signature intact
        strobe(MS_LOCK2, 8'h00); busy_len(n);
        rd(MS_READ, v); chk8("R10 verify locked", v, 8'hFF);
        restart_addr();
        rd(MS_SIG, v); chk8("R11 sig at 0", v, SIG_ID0);
        advance(1);
        rd(MS_SIG, v); chk8("R11 sig at 1", v, SIG_ID1);
        advance(1);
        rd(MS_SIG, v); chk8("R11 sig at 2", v, 8'hFF);

        // short hold ignored, full hold unlocks
        erase_hold(EH - 1, n); chki("R8 short hold ignored", n, 0);
        restart_addr(); advance(2);
        rd(MS_READ, v); chk8("R8 short hold keeps lock", v, 8'hFF);
        erase_hold(EH, n); chki("R8 third erase length", n, DEPTH);
        restart_addr(); advance(1);
        strobe(MS_WRITE, 8'h77); busy_len(n);
        chki("R8 locks cleared by erase", n, WR);
        rd(MS_READ, v); chk8("R8 write after erase", v, 8'h77);

        // clear and advance in the same cycle: clear wins
        advance(2);
        seq_rst = 1'b1; step = 1'b1; tick();
        seq_rst = 1'b0; step = 1'b0; tick();
        rd(MS_READ, v); chk8("R1 clear beats step", v, 8'hFF);
        advance(1);
        rd(MS_READ, v); chk8("R1 next after clear", v, 8'h77);

        // wrap-around
        restart_addr(); advance(DEPTH + 1);
        rd(MS_READ, v); chk8("R2 wrap to start", v, 8'h77);

        // mode/voltage qualification
        hv_en = 1'b1; mode_sel = MS_READ; #1 chk8("R3 read with hv high", rdata, 8'hFF);
        rd(4'hF, v); chk8("R3 undefined code", v, 8'hFF);
        advance(1);
        hv_en = 1'b0; mode_sel = MS_WRITE; wdata = 8'h22;
        prog_n = 1'b0; tick(); prog_n = 1'b1; tick();
        chki("R3 write with hv low no busy", int'(rdy), 1);
        rd(MS_READ, v); chk8("R3 write with hv low no change", v, 8'hFF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule